// File: doc/BRIEF.md
# Ping-Pong Endpoint Bank Controller

This block turns one endpoint of a USB-style device into a double-buffered endpoint. When ping-pong operation is on, the descriptor of the enabled direction (pointer and byte count) serves as bank 0. The descriptor of the unused opposite direction serves as bank 1. The transaction engine always works on the bank named by a bank flag. Meanwhile the CPU or DMA refills or drains the other bank.

The transaction engine reports a start pulse and a completion pulse with a result code. From these the block keeps two 8-bit sticky status registers, one per direction. Flags that describe a transaction's outcome go to the register that owns the bank used. The bank flag, the data toggle and the per-bank busy bits live only in the enabled direction's register. Software clears any status bit by writing a one to it.

A configuration check rejects ping-pong on control endpoints. It also rejects ping-pong when both directions, or neither, are enabled. In those cases the endpoint runs single-buffered.

Top module: `pp_bank_ctrl`

## Requirements
- R1: After reset both status registers read 0x00, the bank flag is 0, and `hostNak` is low.
- R2: With ping-pong active, `actPtr`/`actCnt` show the enabled direction's descriptor while the bank flag is 0, and the opposite direction's descriptor while it is 1. The enabled direction is IN when `cfgEnIn` is 1, otherwise OUT.
- R3: The bank flag, status bit 7 of the enabled direction, inverts one cycle after a completion that consumed the bank. A consuming completion is result 0 (ACK), or result 1 or 2 with `txnConsumed` high. The flag is unchanged after result 3 (NAK) or after an unconsumed error.
- R4: An ACK completion sets status bit 0 when bank 0 carried it, in the enabled direction's register. When bank 1 carried it, the ACK sets bit 1 in the opposite direction's register.
- R5: Result 1 (underflow/overflow) sets status bit 2 and result 2 (CRC error) sets status bit 3. Each goes to the enabled direction's register for bank 0 and to the opposite register for bank 1, whether consumed or not.
- R6: Every ACK inverts the data toggle, status bit 4 of the enabled direction, whichever bank carried it. Hardware never sets bits 4 to 7 of the opposite register.
- R7: A consuming completion sets the busy bit of the bank it used in the enabled direction's register: bit 5 for bank 0, bit 6 for bank 1. One cycle after `txnStart`, `hostNak` equals the busy bit of the current bank. At all other times `hostNak` is low.
- R8: A one in `clrIn`/`clrOut` clears that status bit on the next edge and leaves the other bits alone. A hardware update of the same bit in the same cycle wins.
- R9: With ping-pong requested on a control endpoint (`cfgEpType` = 0), `cfgErr` is 1 and the endpoint runs single-buffered: the bank stays 0 and all flags go to the enabled direction.
- R10: With ping-pong requested and both directions enabled, or neither, `cfgErr` is 1 and the endpoint runs single-buffered.
- R11: With ping-pong off, `cfgErr` is 0, `actPtr`/`actCnt` always show the enabled direction's descriptor, and all flags go to the enabled direction's register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgPingPong | input | 1 | Request double-buffered operation |
| cfgEpType | input | 2 | Endpoint type: 0 control, 1 bulk, 2 interrupt, 3 isochronous |
| cfgEnIn | input | 1 | IN direction enabled |
| cfgEnOut | input | 1 | OUT direction enabled |
| ptrIn | input | PTR_W | IN descriptor buffer pointer |
| cntIn | input | CNT_W | IN descriptor byte count |
| ptrOut | input | PTR_W | OUT descriptor buffer pointer |
| cntOut | input | CNT_W | OUT descriptor byte count |
| txnStart | input | 1 | Transaction start pulse from the engine |
| txnDone | input | 1 | Transaction completion pulse |
| txnRes | input | 2 | Result: 0 ACK, 1 underflow/overflow, 2 CRC error, 3 NAK |
| txnConsumed | input | 1 | Error completion used up the bank |
| clrIn | input | 8 | Write-one-to-clear mask for the IN status register |
| clrOut | input | 8 | Write-one-to-clear mask for the OUT status register |
| actPtr | output | PTR_W | Buffer pointer of the current bank |
| actCnt | output | CNT_W | Byte count of the current bank |
| hostNak | output | 1 | Current bank still owned by software; NAK the host |
| statIn | output | 8 | IN status register |
| statOut | output | 8 | OUT status register |
| cfgErr | output | 1 | Ping-pong request rejected by the configuration check |

## Verification
Status bits, the bank flag and the toggle are registered. They change on the first rising edge after `txnDone` or a clear mask is presented. `actPtr`/`actCnt` follow the bank flag in that same cycle. `hostNak` is registered and answers one edge after `txnStart`. `cfgErr` is combinational and valid in the cycle the configuration is applied. The bench drives on falling edges, holds each pulse for exactly one rising edge, and samples on the next falling edge, so every check reads the value due after that single edge.

// File: rtl/pp_bank_pkg.sv
package pp_bank_pkg;
  typedef enum logic [1:0] {EP_CTRL = 2'd0, EP_BULK = 2'd1, EP_INTR = 2'd2, EP_ISO = 2'd3} epType_e;
  typedef enum logic [1:0] {RES_ACK = 2'd0, RES_UDFOVF = 2'd1, RES_CRC = 2'd2, RES_NAK = 2'd3} txnRes_e;

  localparam int STAT_W  = 8;
  localparam int B_DONE0 = 0;
  localparam int B_DONE1 = 1;
  localparam int B_UDF   = 2;
  localparam int B_CRC   = 3;
  localparam int B_TOG   = 4;
  localparam int B_BUSY0 = 5;
  localparam int B_BUSY1 = 6;
  localparam int B_BANK  = 7;

  // strobes from control to datapath, valid for the current cycle
  typedef struct packed {
    logic primIn;    // enabled direction is IN
    logic bank;      // effective bank in use
    logic setDone;
    logic setUdf;
    logic setCrc;
    logic flipTog;
    logic setBusy;
    logic flipBank;
  } strobe_t;
endpackage

// File: rtl/pp_ctrl.sv
module pp_ctrl
  import pp_bank_pkg::*;
(
  input  logic       cfgPingPong,
  input  logic [1:0] cfgEpType,
  input  logic       cfgEnIn,
  input  logic       cfgEnOut,
  input  logic       txnDone,
  input  logic [1:0] txnRes,
  input  logic       txnConsumed,
  input  logic       bankFlag,
  output strobe_t    strb,
  output logic       ppOn,
  output logic       cfgErr
);
  logic isAck, isErr, consume;

  // reject ping-pong on control endpoints or without exactly one enabled direction
  assign cfgErr  = cfgPingPong && ((cfgEpType == EP_CTRL) || (cfgEnIn == cfgEnOut));
  assign ppOn    = cfgPingPong && !cfgErr;

  assign isAck   = txnDone && (txnRes == RES_ACK);
  assign isErr   = txnDone && ((txnRes == RES_UDFOVF) || (txnRes == RES_CRC));
  assign consume = isAck || (isErr && txnConsumed);

  always_comb begin
    strb          = '0;
    strb.primIn   = cfgEnIn;
    strb.bank     = ppOn && bankFlag;
    strb.setDone  = isAck;
    strb.setUdf   = txnDone && (txnRes == RES_UDFOVF);
    strb.setCrc   = txnDone && (txnRes == RES_CRC);
    strb.flipTog  = isAck;
    strb.setBusy  = consume;
    strb.flipBank = consume && ppOn;
  end
endmodule

// File: rtl/pp_datapath.sv
module pp_datapath
  import pp_bank_pkg::*;
#(
  parameter int PTR_W = 16,
  parameter int CNT_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [STAT_W-1:0] clrIn,
  input  logic [STAT_W-1:0] clrOut,
  input  logic [PTR_W-1:0]  ptrIn,
  input  logic [CNT_W-1:0]  cntIn,
  input  logic [PTR_W-1:0]  ptrOut,
  input  logic [CNT_W-1:0]  cntOut,
  input  logic              txnStart,
  output logic [STAT_W-1:0] statIn,
  output logic [STAT_W-1:0] statOut,
  output logic              bankFlag,
  output logic [PTR_W-1:0]  actPtr,
  output logic [CNT_W-1:0]  actCnt,
  output logic              hostNak
);
  logic [1:0][STAT_W-1:0] statQ;
  logic [1:0][STAT_W-1:0] clrV;
  logic [STAT_W-1:0]      primStat;
  logic                   useIn;

  assign clrV[0] = clrOut;
  assign clrV[1] = clrIn;

  // index 0 holds the OUT register, index 1 the IN register
  for (genvar d = 0; d < 2; d++) begin : g_dir
    localparam logic IS_IN = (d == 1);
    logic              isPrim, isTgt;
    logic [STAT_W-1:0] regQ, regD;

    assign isPrim = (IS_IN == strb.primIn);
    assign isTgt  = isPrim ^ strb.bank;   // bank 1 lands in the opposite register

    always_comb begin
      regD = regQ & ~clrV[d];
      if (isTgt) begin
        if (strb.setDone) regD[strb.bank ? B_DONE1 : B_DONE0] = 1'b1;
        if (strb.setUdf)  regD[B_UDF] = 1'b1;
        if (strb.setCrc)  regD[B_CRC] = 1'b1;
      end
      if (isPrim) begin
        if (strb.flipTog)  regD[B_TOG]  = ~regQ[B_TOG];
        if (strb.setBusy)  regD[strb.bank ? B_BUSY1 : B_BUSY0] = 1'b1;
        if (strb.flipBank) regD[B_BANK] = ~regQ[B_BANK];
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) regQ <= '0;
      else       regQ <= regD;
    end

    assign statQ[d] = regQ;
  end

  assign statOut  = statQ[0];
  assign statIn   = statQ[1];
  assign primStat = strb.primIn ? statQ[1] : statQ[0];
  assign bankFlag = primStat[B_BANK];

  assign useIn  = strb.primIn ^ strb.bank;
  assign actPtr = useIn ? ptrIn : ptrOut;
  assign actCnt = useIn ? cntIn : cntOut;

  always_ff @(posedge clk) begin
    if (!rstN)         hostNak <= 1'b0;
    else if (txnStart) hostNak <= strb.bank ? primStat[B_BUSY1] : primStat[B_BUSY0];
    else               hostNak <= 1'b0;
  end
endmodule

// File: rtl/pp_bank_ctrl.sv
module pp_bank_ctrl
  import pp_bank_pkg::*;
#(
  parameter int PTR_W = 16,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgPingPong,
  input  logic [1:0]       cfgEpType,
  input  logic             cfgEnIn,
  input  logic             cfgEnOut,
  input  logic [PTR_W-1:0] ptrIn,
  input  logic [CNT_W-1:0] cntIn,
  input  logic [PTR_W-1:0] ptrOut,
  input  logic [CNT_W-1:0] cntOut,
  input  logic             txnStart,
  input  logic             txnDone,
  input  logic [1:0]       txnRes,
  input  logic             txnConsumed,
  input  logic [7:0]       clrIn,
  input  logic [7:0]       clrOut,
  output logic [PTR_W-1:0] actPtr,
  output logic [CNT_W-1:0] actCnt,
  output logic             hostNak,
  output logic [7:0]       statIn,
  output logic [7:0]       statOut,
  output logic             cfgErr
);
  strobe_t strb;
  logic    ppOn;
  logic    bankFlag;

  pp_ctrl u_ctrl (
    .cfgPingPong(cfgPingPong), .cfgEpType(cfgEpType),
    .cfgEnIn(cfgEnIn), .cfgEnOut(cfgEnOut),
    .txnDone(txnDone), .txnRes(txnRes), .txnConsumed(txnConsumed),
    .bankFlag(bankFlag), .strb(strb), .ppOn(ppOn), .cfgErr(cfgErr)
  );

  pp_datapath #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .clrIn(clrIn), .clrOut(clrOut),
    .ptrIn(ptrIn), .cntIn(cntIn), .ptrOut(ptrOut), .cntOut(cntOut),
    .txnStart(txnStart),
    .statIn(statIn), .statOut(statOut), .bankFlag(bankFlag),
    .actPtr(actPtr), .actCnt(actCnt), .hostNak(hostNak)
  );
endmodule

// File: rtl/pp_bank_chk.sv
module pp_bank_chk (
  input logic       clk,
  input logic       rstN,
  input logic       txnStart,
  input logic       txnDone,
  input logic [1:0] txnRes,
  input logic       cfgEnIn,
  input logic [7:0] clrIn,
  input logic [7:0] clrOut,
  input logic [7:0] statIn,
  input logic [7:0] statOut,
  input logic       hostNak,
  input logic       ppOn,
  input logic       actBank
);
  logic [7:0] primStat;
  logic [7:0] primClr;
  assign primStat = cfgEnIn ? statIn : statOut;
  assign primClr  = cfgEnIn ? clrIn : clrOut;

  AST_NAK_KEEPS_BANK: assert property (@(posedge clk) disable iff (!rstN)
    (txnDone && txnRes == 2'd3 && !primClr[7]) |=> $stable(actBank)); // R3
  AST_ACK_FLIPS_BANK: assert property (@(posedge clk) disable iff (!rstN)
    (txnDone && txnRes == 2'd0 && ppOn && !primClr[7]) |=> (actBank != $past(actBank))); // R3
  AST_NAK_FOLLOWS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    txnStart |=> (hostNak == $past(actBank ? primStat[6] : primStat[5]))); // R7
  AST_NAK_ONLY_AFTER_START: assert property (@(posedge clk) disable iff (!rstN)
    !txnStart |=> !hostNak); // R7
  AST_CLEAR_CRC_IN: assert property (@(posedge clk) disable iff (!rstN)
    (clrIn[3] && !txnDone) |=> !statIn[3]); // R8
endmodule

bind pp_bank_ctrl pp_bank_chk u_chk (
  .clk(clk), .rstN(rstN), .txnStart(txnStart), .txnDone(txnDone),
  .txnRes(txnRes), .cfgEnIn(cfgEnIn), .clrIn(clrIn), .clrOut(clrOut),
  .statIn(statIn), .statOut(statOut), .hostNak(hostNak),
  .ppOn(ppOn), .actBank(strb.bank)
);

// File: tb/sim_pp_bank_ctrl.sv
`timescale 1ns/1ps
module sim_pp_bank_ctrl;
  localparam int PTR_W = 16;
  localparam int CNT_W = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgPingPong = 1'b0;
  logic [1:0] cfgEpType = 2'd1;
  logic cfgEnIn = 1'b0;
  logic cfgEnOut = 1'b1;
  logic [PTR_W-1:0] ptrIn = 16'h1000;
  logic [CNT_W-1:0] cntIn = 10'd64;
  logic [PTR_W-1:0] ptrOut = 16'h2000;
  logic [CNT_W-1:0] cntOut = 10'd32;
  logic txnStart = 1'b0, txnDone = 1'b0, txnConsumed = 1'b0;
  logic [1:0] txnRes = 2'd0;
  logic [7:0] clrIn = '0, clrOut = '0;
  logic [PTR_W-1:0] actPtr;
  logic [CNT_W-1:0] actCnt;
  logic hostNak, cfgErr;
  logic [7:0] statIn, statOut;

  int nRun = 0;
  int nFail = 0;

  always #2 clk = ~clk;   // 250 MHz

  pp_bank_ctrl #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .cfgPingPong(cfgPingPong), .cfgEpType(cfgEpType),
    .cfgEnIn(cfgEnIn), .cfgEnOut(cfgEnOut), .ptrIn(ptrIn), .cntIn(cntIn),
    .ptrOut(ptrOut), .cntOut(cntOut), .txnStart(txnStart), .txnDone(txnDone),
    .txnRes(txnRes), .txnConsumed(txnConsumed), .clrIn(clrIn), .clrOut(clrOut),
    .actPtr(actPtr), .actCnt(actCnt), .hostNak(hostNak),
    .statIn(statIn), .statOut(statOut), .cfgErr(cfgErr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic chkStat(input string req, input logic [7:0] eIn, input logic [7:0] eOut);
    chk({req, " statIn"}, {24'd0, statIn}, {24'd0, eIn});
    chk({req, " statOut"}, {24'd0, statOut}, {24'd0, eOut});
  endtask

  // one completion pulse held for one rising edge, sampled at the next falling edge
  task automatic txn(input logic [1:0] res, input logic cons, input logic [7:0] cI = 8'h00);
    @(negedge clk);
    txnDone = 1'b1; txnRes = res; txnConsumed = cons; clrIn = cI;
    @(negedge clk);
    txnDone = 1'b0; txnConsumed = 1'b0; clrIn = '0;
  endtask

  task automatic startTxn(output logic nak);
    @(negedge clk);
    txnStart = 1'b1;
    @(negedge clk);
    txnStart = 1'b0;
    nak = hostNak;
  endtask

  task automatic clearAll();
    @(negedge clk);
    clrIn = 8'hFF; clrOut = 8'hFF;
    @(negedge clk);
    clrIn = '0; clrOut = '0;
  endtask

  task automatic setCfg(input logic pp, input logic [1:0] ty, input logic eIn, input logic eOut);
    @(negedge clk);
    cfgPingPong = pp; cfgEpType = ty; cfgEnIn = eIn; cfgEnOut = eOut;
  endtask

  task automatic testReset();
    chkStat("R1 reset", 8'h00, 8'h00);
    chk("R1 hostNak", {31'd0, hostNak}, 32'd0);
    chk("R11 cfgErr pp off", {31'd0, cfgErr}, 32'd0);
  endtask

  task automatic testBanks();
    setCfg(1'b1, 2'd1, 1'b1, 1'b0);
    #0;
    chk("R10 cfg ok", {31'd0, cfgErr}, 32'd0);
    chk("R2 bank0 ptr", {16'd0, actPtr}, 32'h1000);
    txn(2'd0, 1'b0);
    chkStat("R3 R4 R6 R7 ack bank0", 8'hB1, 8'h00);
    chk("R2 bank1 ptr", {16'd0, actPtr}, 32'h2000);
    chk("R2 bank1 cnt", {22'd0, actCnt}, 32'd32);
    txn(2'd0, 1'b0);
    chkStat("R4 R6 ack bank1", 8'h61, 8'h02);
    chk("R2 back to bank0", {16'd0, actPtr}, 32'h1000);
  endtask

  task automatic testNak();
    logic n;
    startTxn(n);
    chk("R7 busy bank0 nak", {31'd0, n}, 32'd1);
    @(negedge clk);
    chk("R7 nak one cycle", {31'd0, hostNak}, 32'd0);
    clrIn = 8'h20;
    @(negedge clk);
    clrIn = '0;
    chkStat("R8 clear busy0", 8'h41, 8'h02);
    startTxn(n);
    chk("R7 free bank0 no nak", {31'd0, n}, 32'd0);
    txn(2'd3, 1'b0);
    chkStat("R3 nak result holds", 8'h41, 8'h02);
  endtask

  task automatic testErrors();
    logic n;
    txn(2'd1, 1'b0);
    chkStat("R5 R3 udf unconsumed bank0", 8'h45, 8'h02);
    txn(2'd2, 1'b1);
    chkStat("R5 R3 R7 crc consumed bank0", 8'hED, 8'h02);
    chk("R2 bank1 after err", {16'd0, actPtr}, 32'h2000);
    startTxn(n);
    chk("R7 busy bank1 nak", {31'd0, n}, 32'd1);
    txn(2'd2, 1'b0);
    chkStat("R5 crc bank1 opposite", 8'hED, 8'h0A);
    txn(2'd1, 1'b1);
    chkStat("R5 R3 udf consumed bank1", 8'h6D, 8'h0E);
  endtask

  task automatic testClear();
    clearAll();
    chkStat("R8 clear all", 8'h00, 8'h00);
    chk("R8 bank reset ptr", {16'd0, actPtr}, 32'h1000);
    txn(2'd0, 1'b0, 8'h01);
    chkStat("R8 hw set wins", 8'hB1, 8'h00);
    clearAll();
  endtask

  task automatic testControl();
    setCfg(1'b1, 2'd0, 1'b1, 1'b0);
    #0;
    chk("R9 cfgErr control", {31'd0, cfgErr}, 32'd1);
    txn(2'd0, 1'b0);
    chkStat("R9 single bank", 8'h31, 8'h00);
    chk("R9 ptr stays bank0", {16'd0, actPtr}, 32'h1000);
    txn(2'd0, 1'b0);
    chkStat("R9 R6 second ack", 8'h21, 8'h00);
  endtask

  task automatic testBothDirs();
    setCfg(1'b1, 2'd1, 1'b1, 1'b1);
    clearAll();
    chk("R10 cfgErr both dirs", {31'd0, cfgErr}, 32'd1);
    txn(2'd0, 1'b0);
    chkStat("R10 single bank", 8'h31, 8'h00);
    chk("R10 ptr bank0", {16'd0, actPtr}, 32'h1000);
    setCfg(1'b1, 2'd2, 1'b0, 1'b0);
    #0;
    chk("R10 cfgErr no dirs", {31'd0, cfgErr}, 32'd1);
  endtask

  task automatic testSingle();
    setCfg(1'b0, 2'd1, 1'b0, 1'b1);
    clearAll();
    chk("R11 cfgErr", {31'd0, cfgErr}, 32'd0);
    chk("R11 ptr out", {16'd0, actPtr}, 32'h2000);
    txn(2'd0, 1'b0);
    chkStat("R11 ack", 8'h00, 8'h31);
    txn(2'd0, 1'b0);
    chkStat("R11 ack2", 8'h00, 8'h21);
    chk("R11 ptr fixed", {16'd0, actPtr}, 32'h2000);
  endtask

  task automatic testOutPingPong();
    setCfg(1'b1, 2'd3, 1'b0, 1'b1);
    clearAll();
    chk("R2 out bank0 ptr", {16'd0, actPtr}, 32'h2000);
    txn(2'd0, 1'b0);
    chkStat("R4 R6 out ack bank0", 8'h00, 8'hB1);
    chk("R2 out bank1 ptr", {16'd0, actPtr}, 32'h1000);
    chk("R2 out bank1 cnt", {22'd0, actCnt}, 32'd64);
    txn(2'd0, 1'b0);
    chkStat("R4 R6 out ack bank1", 8'h02, 8'h61);
  endtask

  initial begin
    #1000000;
    nFail++;
    $display("FAIL watchdog R1..: act=running exp=finished");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBanks();
    testNak();
    testErrors();
    testClear();
    testControl();
    testBothDirs();
    testSingle();
    testOutPingPong();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule